// File: doc/BRIEF.md
# Privileged Countdown Interval Timer

This block lets an operating system take the processor back after a set time. A prescaler divides the system clock into evenly spaced ticks, nominally fifty per second. A down-counter loses one on each tick. When it reaches zero, the block raises an interrupt so that the kernel regains control, for example to switch between time-shared tasks.

The count can be written only by a load that is marked as coming from monitor (kernel) mode. A load marked as user mode is refused. It raises a one-cycle fault and leaves the timer exactly as it was. Once the count is at zero it stays there, and the interrupt stays asserted until software acknowledges it or loads a new count. Loading zero raises the interrupt at once.

Top module: `priv_interval_timer`

## Requirements
- R1: After synchronous reset, `irq` and `fault` are low, the count is zero, and `irq` stays low with no load applied.
- R2: A load with `ld_valid`=1 and `ld_mode`=0 (monitor) is accepted. The count takes `ld_value` at that clock edge and the prescaler phase restarts, so the first decrement happens PRESCALE_DIV edges later.
- R3: The count drops by exactly one per tick, and a tick occurs once every PRESCALE_DIV clock cycles.
- R4: After an accepted load of V>0 with no later load, `irq` rises at the edge that is V*PRESCALE_DIV edges after the load edge, and not before.
- R5: At zero the count holds, and `irq` stays asserted until it is acknowledged or a load is accepted.
- R6: `irq_ack`=1 clears `irq` at the next edge. While the count rests at zero, the interrupt is not raised again.
- R7: An accepted load of 0 sets `irq` at the load edge.
- R8: An accepted load of a nonzero value clears a pending `irq` at the load edge.
- R9: A load with `ld_valid`=1 and `ld_mode`=1 (user) sets `fault` high for exactly the next cycle. It changes neither the count nor the prescaler phase, so the expiry time is unchanged.
- R10: If an acknowledge coincides with the tick that takes the count to zero, the expiry wins and `irq` is set. If an acknowledge coincides with an accepted load, the load decides `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request strobe |
| ld_mode | input | 1 | Privilege of the request: 0 monitor, 1 user |
| ld_value | input | CNT_W | Count to load, in ticks |
| irq_ack | input | 1 | Clears a pending interrupt |
| irq | output | 1 | Timer expiry interrupt, held until cleared |
| fault | output | 1 | One-cycle pulse for a refused user-mode load |

## Verification
The main countdown is run with loads of several sizes: 1, 3 and 5 ticks, a reload in mid-count, and a load of zero. The interrupt is sampled one edge before and one edge at the predicted expiry, which separates a correct prescaler phase from an off-by-one tick or a missing restart on load. A user-mode load is placed in the middle of a countdown. Because the expiry must still come at the original time, this shows the refusal touched neither the count nor the phase. Acknowledges are applied alone, together with an expiry, and together with loads of zero and nonzero values, which settles the priority between clearing, expiring and reloading.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic {
        PRIV_MONITOR = 1'b0,
        PRIV_USER    = 1'b1
    } priv_mode_e;

    typedef struct packed {
        logic accept;
        logic reject;
    } wr_decision_t;

    function automatic wr_decision_t decide_write(input logic valid, input priv_mode_e mode);
        wr_decision_t d;
        d.accept = valid && (mode == PRIV_MONITOR);
        d.reject = valid && (mode == PRIV_USER);
        return d;
    endfunction

    function automatic int unsigned ticks_div(input int unsigned clk_hz, input int unsigned tick_hz);
        int unsigned q;
        q = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            assign tick = (phase == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R3
            AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (rst)
                restart |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/pit_priv_gate.sv
module pit_priv_gate
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  priv_mode_e wr_mode,
    output logic       accept,
    output logic       fault
);
    wr_decision_t dec;

    always_comb dec = decide_write(wr_valid, wr_mode);
    assign accept = dec.accept;

    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= dec.reject;
    end

    AST_USER_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_mode == PRIV_USER) |=> fault); // R9
    AST_FAULT_ONLY_USER: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && wr_mode == PRIV_USER) |=> !fault); // R9
    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(accept && dec.reject)); // R9
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         ack,
    output logic [W-1:0] remain,
    output logic         irq
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] remain;
        logic         pending;
    } state_t;

    state_t cur, nxt;
    logic   expire;

    always_comb begin
        nxt    = cur;
        expire = 1'b0;
        if (load_en) begin
            nxt.remain  = load_val;
            nxt.pending = (load_val == '0);
        end else begin
            if (tick && cur.remain != '0) nxt.remain = cur.remain - ONE;
            expire = tick && (cur.remain == ONE);
            if (expire)   nxt.pending = 1'b1;
            else if (ack) nxt.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign remain = cur.remain;
    assign irq    = cur.pending;

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && remain != '0) |=> remain == $past(remain) - ONE); // R3
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load_en && remain == '0) |=> remain == '0); // R5
    AST_EXPIRE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && remain == ONE) |=> irq); // R4
    AST_HOLD_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq && !load_en && !ack) |=> irq); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !load_en && !(tick && remain == ONE)) |=> !irq); // R6
    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_val == '0) |=> irq); // R7
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_val != '0) |=> (!irq && remain == $past(load_val))); // R8
endmodule

// File: rtl/priv_interval_timer.sv
module priv_interval_timer
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned CLK_HZ       = 100_000_000,
    parameter int unsigned TICK_HZ      = 50,
    parameter int unsigned PRESCALE_DIV = ticks_div(CLK_HZ, TICK_HZ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic             ld_mode,
    input  logic [CNT_W-1:0] ld_value,
    input  logic             irq_ack,
    output logic             irq,
    output logic             fault
);
    priv_mode_e       mode;
    logic             accept;
    logic             tick;
    logic [CNT_W-1:0] remain;

    assign mode = priv_mode_e'(ld_mode);

    pit_priv_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (ld_valid),
        .wr_mode  (mode),
        .accept   (accept),
        .fault    (fault)
    );

    pit_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    pit_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_en  (accept),
        .load_val (ld_value),
        .ack      (irq_ack),
        .remain   (remain),
        .irq      (irq)
    );

    AST_USER_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_mode && !tick) |=> $stable(remain)); // R9
    AST_MONITOR_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_mode) |=> remain == $past(ld_value)); // R2
endmodule

// File: tb/sim_priv_interval_timer.sv
module sim_priv_interval_timer;
    localparam int unsigned W   = 8;
    localparam int unsigned DIV = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_valid = 1'b0;
    logic         ld_mode  = 1'b0;
    logic [W-1:0] ld_value = '0;
    logic         irq_ack  = 1'b0;
    logic         irq, fault;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    priv_interval_timer #(.CNT_W(W), .PRESCALE_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_mode(ld_mode),
        .ld_value(ld_value), .irq_ack(irq_ack), .irq(irq), .fault(fault)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one edge with a load request; returns at the negedge after it
    task automatic load(input logic [W-1:0] v, input logic user, input logic ack);
        ld_valid = 1'b1; ld_mode = user; ld_value = v; irq_ack = ack;
        @(negedge clk);
        ld_valid = 1'b0; ld_mode = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk(irq, 1'b0, "R1", "irq after reset");
        chk(fault, 1'b0, "R1", "fault after reset");
        edges(30);
        chk(irq, 1'b0, "R1", "irq idle with no load");
    endtask

    task automatic t_countdown(input int v);
        load(W'(v), 1'b0, 1'b0);
        edges(v * DIV - 1);
        chk(irq, 1'b0, "R4", $sformatf("no irq one edge early, V=%0d", v));
        edges(1);
        chk(irq, 1'b1, "R4", $sformatf("irq at expiry, V=%0d (R2 R3 timing)", v));
        edges(20);
        chk(irq, 1'b1, "R5", "irq held at zero");
        ack_once();
        chk(irq, 1'b0, "R6", "ack clears irq");
        edges(20);
        chk(irq, 1'b0, "R6", "no re-raise while resting at zero");
    endtask

    task automatic t_reload_mid();
        load(8'd5, 1'b0, 1'b0);
        edges(6);
        load(8'd2, 1'b0, 1'b0);
        edges(2 * DIV - 1);
        chk(irq, 1'b0, "R2", "reload restarts count and phase, early");
        edges(1);
        chk(irq, 1'b1, "R2", "reload expiry on time");
        ack_once();
    endtask

    task automatic t_load_zero();
        load(8'd0, 1'b0, 1'b0);
        chk(irq, 1'b1, "R7", "load zero raises irq at once");
        load(8'd3, 1'b0, 1'b0);
        chk(irq, 1'b0, "R8", "nonzero load clears pending irq");
        edges(3 * DIV - 1);
        chk(irq, 1'b0, "R8", "no irq before new expiry");
        edges(1);
        chk(irq, 1'b1, "R8", "new expiry after clearing load");
        ack_once();
    endtask

    task automatic t_user_reject();
        load(8'd3, 1'b0, 1'b0);
        edges(2);
        load(8'd1, 1'b1, 1'b0);
        chk(fault, 1'b1, "R9", "fault after user load");
        edges(1);
        chk(fault, 1'b0, "R9", "fault lasts one cycle");
        edges(3 * DIV - 2 - 1 - 1 - 1);
        chk(irq, 1'b0, "R9", "user load left count, no early irq");
        edges(1);
        chk(irq, 1'b1, "R9", "expiry time unchanged by user load");
        load(8'd0, 1'b1, 1'b0);
        chk(fault, 1'b1, "R9", "fault on user load while pending");
        chk(irq, 1'b1, "R9", "user load of zero does not touch irq");
        ack_once();
        chk(fault, 1'b0, "R9", "no fault from monitor activity");
    endtask

    task automatic t_priority();
        load(8'd1, 1'b0, 1'b0);
        edges(DIV - 1);
        ack_once();
        chk(irq, 1'b1, "R10", "expiry wins over coincident ack");
        load(8'd0, 1'b0, 1'b1);
        chk(irq, 1'b1, "R10", "load zero with ack leaves irq set");
        load(8'd5, 1'b0, 1'b1);
        chk(irq, 1'b0, "R10", "load nonzero with ack clears irq");
        edges(5 * DIV - 1);
        chk(irq, 1'b0, "R10", "no early irq after load with ack");
        edges(1);
        chk(irq, 1'b1, "R10", "expiry after load with ack");
        ack_once();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        edges(3);
        rst = 1'b0;
        t_reset();
        t_countdown(1);
        t_countdown(3);
        t_countdown(5);
        t_reload_mid();
        t_load_zero();
        t_user_reject();
        t_priority();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule